// File: doc/BRIEF.md
# Reloading Countdown Timer with Interrupt

This block is an 8-bit down-counter that reloads itself. It is clocked by one of four tick rates: 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz. All four rates are derived as single-cycle enables from one 8192 Hz base enable, and no derived clock is used.

Software loads a count value `n`. The counter then steps from `n` down to 1 and reloads `n`. At each reload it sets a sticky timer flag. The active-low interrupt output works in one of two modes:

- Level mode: the output follows the flag.
- Pulse mode: each reload produces a low pulse of fixed length, timed in base ticks.

The register-side ports are plain write strobes with data, plus read-back values. Reading the count returns the live counter, not the loaded value.

The base-tick ratios are parameters:

- `BASE_PER_4K` (default 2) is the number of base ticks per 4096 Hz tick.
- `BASE_PER_64` (default 128) is the number of base ticks per 64 Hz tick.
- `BASE_PER_1` (default 8192) is the number of base ticks per 1 Hz tick.
- `SEC_PER_MIN` (default 60) is the number of 1 Hz ticks per 1/60 Hz tick.

Top module: `tick_countdown_timer`

## Requirements
- R1: After reset, `cfgRd` reads 5'b01100. Its fields are [4]=timer enable 0, [3:2]=source select 2'b11, [1]=interrupt enable 0 and [0]=pulse mode 0. Also after reset, `cntRd` is 0, `flagRd` is 0 and `intN` is 1.
- R2: With a nonzero count `n` loaded and the timer enabled, `cntRd` takes one step per selected tick in the sequence n, n-1, ..., 1, n, and so on.
- R3: Source select 2'b00 steps every `BASE_PER_4K` base ticks. 2'b01 steps every `BASE_PER_64` base ticks. 2'b10 steps every `BASE_PER_1` base ticks. 2'b11 steps every `BASE_PER_1*SEC_PER_MIN` base ticks.
- R4: A loaded count of 0 stops the timer. The count stays at 0 and the flag is never set.
- R5: The flag is set in the cycle after each reload. A flag write with data 0 clears it, and a flag write with data 1 leaves it unchanged. If a reload and a clear fall in the same cycle, the set wins.
- R6: When pulse mode is 0, `intN` is low exactly when the flag is 1 and the interrupt enable is 1.
- R7: When pulse mode is 1, each reload drives `intN` low starting in the same cycle the flag sets. The pulse length in base ticks depends on the source and on `n`:
  - At 4096 Hz: `BASE_PER_4K/2` base ticks for n=1, and `BASE_PER_4K` base ticks for n>1.
  - At 64 Hz: `BASE_PER_64/2` base ticks for n=1, and `BASE_PER_64` base ticks for n>1.
  - At 1 Hz and 1/60 Hz: `BASE_PER_64` base ticks.
- R8: With the interrupt enable at 0, `intN` stays high in both modes, while the flag still sets.
- R9: A count write loads both the reload value and the live counter. `cntRd` shows the new value in the next cycle, and counting continues down from it.
- R10: Writing the timer enable to 0 freezes `cntRd` and ends any interrupt pulse in progress in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | 8192 Hz base enable, one cycle wide |
| cfgWr | input | 1 | Write strobe for the four configuration fields |
| cfgTimerEn | input | 1 | Timer enable data |
| cfgSrcSel | input | 2 | Tick source select data |
| cfgIntEn | input | 1 | Interrupt enable data |
| cfgPulseMode | input | 1 | Interrupt mode data (1 = pulse) |
| cntWr | input | 1 | Count write strobe |
| cntWrData | input | 8 | Count value to load |
| flagWr | input | 1 | Flag write strobe |
| flagWrData | input | 1 | Flag write data (0 clears) |
| cfgRd | output | 5 | Configuration read-back {en, sel[1:0], ie, pulse} |
| cntRd | output | 8 | Live count value |
| flagRd | output | 1 | Timer flag |
| intN | output | 1 | Active-low interrupt |

## Verification
The main countdown is exercised by a table of count and source pairs. The table covers n=1 and n>1 at each of the four sources, and for each pair the spacing and length of the interrupt pulses are measured:

- The spacing between pulse starts confirms the source decode and the reload period.
- The pulse length separates the half-width case at n=1 from the full-width case, which only differ at the two faster sources.

Directed patterns cover the remaining behaviour:

- The live count sequence 3, 2, 1, 3.
- A count rewrite in mid-run.
- A count of zero.
- Flag writes with data 1 versus data 0.
- Level mode versus a disabled interrupt.
- Disabling the timer in the middle of a pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } tmr_strobe_t;

  typedef struct packed {
    logic       en;
    logic [1:0] sel;
    logic       ie;
    logic       pulse;
  } tmr_cfg_t;

  localparam logic [1:0] SRC_4K  = 2'b00;
  localparam logic [1:0] SRC_64  = 2'b01;
  localparam logic [1:0] SRC_1   = 2'b10;
  localparam logic [1:0] SRC_MIN = 2'b11;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int BASE_PER_4K = 2,
  parameter int BASE_PER_64 = 128,
  parameter int BASE_PER_1  = 8192,
  parameter int SEC_PER_MIN = 60
) (
  input  logic clk,
  input  logic rstN,
  input  logic baseTick,
  output logic tick4k,
  output logic tick64,
  output logic tick1,
  output logic tickMin
);
  localparam int DIV_A = BASE_PER_4K;
  localparam int DIV_B = BASE_PER_64 / BASE_PER_4K;
  localparam int DIV_C = BASE_PER_1 / BASE_PER_64;
  localparam int DIV_D = SEC_PER_MIN;
  localparam int WA = (DIV_A > 1) ? $clog2(DIV_A) : 1;
  localparam int WB = (DIV_B > 1) ? $clog2(DIV_B) : 1;
  localparam int WC = (DIV_C > 1) ? $clog2(DIV_C) : 1;
  localparam int WD = (DIV_D > 1) ? $clog2(DIV_D) : 1;
  localparam logic [WA-1:0] LAST_A = WA'(DIV_A - 1);
  localparam logic [WB-1:0] LAST_B = WB'(DIV_B - 1);
  localparam logic [WC-1:0] LAST_C = WC'(DIV_C - 1);
  localparam logic [WD-1:0] LAST_D = WD'(DIV_D - 1);

  logic [WA-1:0] cntA;
  logic [WB-1:0] cntB;
  logic [WC-1:0] cntC;
  logic [WD-1:0] cntD;

  assign tick4k  = baseTick && (cntA == LAST_A);
  assign tick64  = tick4k   && (cntB == LAST_B);
  assign tick1   = tick64   && (cntC == LAST_C);
  assign tickMin = tick1    && (cntD == LAST_D);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntA <= '0;
      cntB <= '0;
      cntC <= '0;
      cntD <= '0;
    end else begin
      if (baseTick) cntA <= (cntA == LAST_A) ? '0 : cntA + WA'(1);
      if (tick4k)   cntB <= (cntB == LAST_B) ? '0 : cntB + WB'(1);
      if (tick64)   cntC <= (cntC == LAST_C) ? '0 : cntC + WC'(1);
      if (tick1)    cntD <= (cntD == LAST_D) ? '0 : cntD + WD'(1);
    end
  end

  // R3: a slower tick only ever fires together with the 4096 Hz tick
  p_ticks_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick64 || tick1 || tickMin) |-> tick4k);

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmr_strobe_t        strb,
  input  logic [COUNT_W-1:0] wrData,
  output logic [COUNT_W-1:0] curOut,
  output logic               reloadIsOne,
  output logic               wrap
);
  logic [COUNT_W-1:0] curCnt;
  logic [COUNT_W-1:0] reloadVal;

  assign curOut      = curCnt;
  assign reloadIsOne = (reloadVal == COUNT_W'(1));
  assign wrap        = strb.step && !strb.load && (reloadVal != '0) && (curCnt <= COUNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCnt    <= '0;
      reloadVal <= '0;
    end else if (strb.load) begin
      curCnt    <= wrData;
      reloadVal <= wrData;
    end else if (strb.step && reloadVal != '0) begin
      curCnt <= wrap ? reloadVal : curCnt - COUNT_W'(1);
    end
  end

  // R2: the live count never rises above the reload value
  p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rstN)
    curCnt <= reloadVal);

  // R4: with a zero reload and no new load the count holds
  p_zero_stops_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reloadVal == '0 && !strb.load) |=> $stable(curCnt));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int BASE_PER_4K = 2,
  parameter int BASE_PER_64 = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        baseTick,
  input  logic        tick4k,
  input  logic        tick64,
  input  logic        tick1,
  input  logic        tickMin,
  input  logic        cfgWr,
  input  tmr_cfg_t    cfgIn,
  input  logic        cntWr,
  input  logic        flagWr,
  input  logic        flagWrData,
  input  logic        wrap,
  input  logic        reloadIsOne,
  output tmr_strobe_t strb,
  output tmr_cfg_t    cfgQ,
  output logic        flagQ,
  output logic        intN
);
  localparam int PW = $clog2(BASE_PER_64 + 1);
  localparam logic [PW-1:0] W_HALF4K = PW'(BASE_PER_4K / 2);
  localparam logic [PW-1:0] W_FULL4K = PW'(BASE_PER_4K);
  localparam logic [PW-1:0] W_HALF64 = PW'(BASE_PER_64 / 2);
  localparam logic [PW-1:0] W_FULL64 = PW'(BASE_PER_64);

  logic          selTick;
  logic [PW-1:0] pulseLeft;
  logic [PW-1:0] pulseWidth;
  logic          killPulse;

  always_comb begin
    unique case (cfgQ.sel)
      SRC_4K:  selTick = tick4k;
      SRC_64:  selTick = tick64;
      SRC_1:   selTick = tick1;
      default: selTick = tickMin;
    endcase
  end

  always_comb begin
    unique case (cfgQ.sel)
      SRC_4K:  pulseWidth = reloadIsOne ? W_HALF4K : W_FULL4K;
      SRC_64:  pulseWidth = reloadIsOne ? W_HALF64 : W_FULL64;
      default: pulseWidth = W_FULL64;
    endcase
  end

  assign strb.load = cntWr;
  assign strb.step = cfgQ.en && selTick;
  assign killPulse = cfgWr && !cfgIn.en;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '{en: 1'b0, sel: SRC_MIN, ie: 1'b0, pulse: 1'b0};
    end else if (cfgWr) begin
      cfgQ <= cfgIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      flagQ <= 1'b0;
    else if (wrap)                  flagQ <= 1'b1;
    else if (flagWr && !flagWrData) flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              pulseLeft <= '0;
    else if (killPulse)                     pulseLeft <= '0;
    else if (wrap)                          pulseLeft <= pulseWidth;
    else if (baseTick && pulseLeft != '0)   pulseLeft <= pulseLeft - PW'(1);
  end

  assign intN = !(cfgQ.ie && (cfgQ.pulse ? (pulseLeft != '0) : flagQ));

  // R5: every reload leaves the flag set
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> flagQ);

  // R5: only a write of 0 can drop the flag
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(flagWr && !flagWrData)) |=> flagQ);

  // R10: no pulse survives while the timer is disabled
  p_pulse_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.en |-> (pulseLeft == '0));

  // R8: interrupt stays released when its enable is off
  p_int_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.ie |-> intN);

endmodule

// File: rtl/tick_countdown_timer.sv
module tick_countdown_timer
  import tmr_pkg::*;
#(
  parameter int COUNT_W     = 8,
  parameter int BASE_PER_4K = 2,
  parameter int BASE_PER_64 = 128,
  parameter int BASE_PER_1  = 8192,
  parameter int SEC_PER_MIN = 60
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseTick,
  input  logic               cfgWr,
  input  logic               cfgTimerEn,
  input  logic [1:0]         cfgSrcSel,
  input  logic               cfgIntEn,
  input  logic               cfgPulseMode,
  input  logic               cntWr,
  input  logic [COUNT_W-1:0] cntWrData,
  input  logic               flagWr,
  input  logic               flagWrData,
  output logic [4:0]         cfgRd,
  output logic [COUNT_W-1:0] cntRd,
  output logic               flagRd,
  output logic               intN
);
  logic        tick4k, tick64, tick1, tickMin;
  logic        wrap, reloadIsOne;
  tmr_strobe_t strb;
  tmr_cfg_t    cfgIn, cfgQ;

  assign cfgIn = '{en: cfgTimerEn, sel: cfgSrcSel, ie: cfgIntEn, pulse: cfgPulseMode};
  assign cfgRd = cfgQ;

  tmr_tick_gen #(
    .BASE_PER_4K(BASE_PER_4K), .BASE_PER_64(BASE_PER_64),
    .BASE_PER_1(BASE_PER_1), .SEC_PER_MIN(SEC_PER_MIN)
  ) u_ticks (
    .clk(clk), .rstN(rstN), .baseTick(baseTick),
    .tick4k(tick4k), .tick64(tick64), .tick1(tick1), .tickMin(tickMin)
  );

  tmr_ctrl #(.BASE_PER_4K(BASE_PER_4K), .BASE_PER_64(BASE_PER_64)) u_ctrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick),
    .tick4k(tick4k), .tick64(tick64), .tick1(tick1), .tickMin(tickMin),
    .cfgWr(cfgWr), .cfgIn(cfgIn), .cntWr(cntWr),
    .flagWr(flagWr), .flagWrData(flagWrData),
    .wrap(wrap), .reloadIsOne(reloadIsOne),
    .strb(strb), .cfgQ(cfgQ), .flagQ(flagRd), .intN(intN)
  );

  tmr_datapath #(.COUNT_W(COUNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(cntWrData),
    .curOut(cntRd), .reloadIsOne(reloadIsOne), .wrap(wrap)
  );

endmodule

// File: tb/tick_countdown_timer_bench.sv
module tick_countdown_timer_bench;
  localparam int B1   = 512;
  localparam int BMIN = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b1;
  logic       cfgWr = 1'b0, cfgTimerEn = 1'b0, cfgIntEn = 1'b0, cfgPulseMode = 1'b0;
  logic [1:0] cfgSrcSel = 2'b00;
  logic       cntWr = 1'b0;
  logic [7:0] cntWrData = 8'd0;
  logic       flagWr = 1'b0, flagWrData = 1'b0;
  logic [4:0] cfgRd;
  logic [7:0] cntRd;
  logic       flagRd, intN;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_countdown_timer #(.BASE_PER_1(B1), .SEC_PER_MIN(BMIN)) u_tick_countdown_timer (
    .clk(clk), .rstN(rstN), .baseTick(baseTick),
    .cfgWr(cfgWr), .cfgTimerEn(cfgTimerEn), .cfgSrcSel(cfgSrcSel),
    .cfgIntEn(cfgIntEn), .cfgPulseMode(cfgPulseMode),
    .cntWr(cntWr), .cntWrData(cntWrData), .flagWr(flagWr), .flagWrData(flagWrData),
    .cfgRd(cfgRd), .cntRd(cntRd), .flagRd(flagRd), .intN(intN)
  );

  // pulse table: source, n, expected low width, expected fall-to-fall period (cycles)
  localparam int NV = 7;
  localparam int VSEL[NV] = '{0, 0, 1, 1, 2, 3, 2};
  localparam int VN  [NV] = '{3, 1, 1, 2, 1, 1, 2};
  localparam int VW  [NV] = '{2, 1, 64, 128, 128, 128, 128};
  localparam int VP  [NV] = '{6, 2, 128, 256, 512, 2048, 1024};

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic en, input logic [1:0] sel, input logic ie, input logic md);
    @(negedge clk);
    cfgWr = 1'b1; cfgTimerEn = en; cfgSrcSel = sel; cfgIntEn = ie; cfgPulseMode = md;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic writeCnt(input logic [7:0] v);
    @(negedge clk);
    cntWr = 1'b1; cntWrData = v;
    @(negedge clk);
    cntWr = 1'b0;
  endtask

  task automatic writeFlag(input logic v);
    @(negedge clk);
    flagWr = 1'b1; flagWrData = v;
    @(negedge clk);
    flagWr = 1'b0;
  endtask

  task automatic nextCount(output int v);
    int prev;
    prev = cntRd;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (cntRd != prev) break;
    end
    v = cntRd;
  endtask

  task automatic waitFall(output bit ok);
    logic prev;
    ok = 0;
    prev = intN;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (prev && !intN) begin ok = 1; break; end
      prev = intN;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    int v;
    bit ok;
    int lowCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfgRd", cfgRd, 5'b01100);
    check("R1 cntRd", cntRd, 0);
    check("R1 flagRd", flagRd, 0);
    check("R1 intN", intN, 1);

    // R2 live sequence n=3 at 4096 Hz
    writeCnt(8'd3);
    check("R9 load visible", cntRd, 3);
    writeCfg(1'b1, 2'b00, 1'b0, 1'b0);
    begin
      int exp[6] = '{2, 1, 3, 2, 1, 3};
      for (int i = 0; i < 6; i++) begin
        nextCount(v);
        check("R2 sequence", v, exp[i]);
      end
    end

    // R9 rewrite while running
    writeCnt(8'd9);
    check("R9 rewrite", cntRd, 9);
    nextCount(v);
    check("R9 continue", v, 8);

    // R5 flag behaviour, timer stopped so no new set
    writeCfg(1'b0, 2'b00, 1'b0, 1'b0);
    check("R5 flag set", flagRd, 1);
    writeFlag(1'b1);
    check("R5 write1 keeps", flagRd, 1);
    writeFlag(1'b0);
    check("R5 write0 clears", flagRd, 0);
    // R10 freeze on disable
    v = cntRd;
    repeat (20) @(negedge clk);
    check("R10 count frozen", cntRd, v);

    // R6 level mode
    writeCfg(1'b0, 2'b00, 1'b1, 1'b0);
    check("R6 idle high", intN, 1);
    writeCnt(8'd1);
    writeCfg(1'b1, 2'b00, 1'b1, 1'b0);
    for (int i = 0; i < 100 && !flagRd; i++) @(negedge clk);
    check("R6 flag up", flagRd, 1);
    check("R6 level low", intN, 0);
    writeCfg(1'b0, 2'b00, 1'b1, 1'b0);
    check("R6 stays low while flag", intN, 0);
    writeFlag(1'b0);
    check("R6 released", intN, 1);

    // R4 zero count stops
    writeCnt(8'd0);
    writeCfg(1'b1, 2'b00, 1'b1, 1'b1);
    repeat (60) @(negedge clk);
    check("R4 count zero", cntRd, 0);
    check("R4 no flag", flagRd, 0);

    // R3 / R7 pulse table
    for (int k = 0; k < NV; k++) begin
      int width, period;
      bit inLow;
      logic prev;
      writeCfg(1'b0, VSEL[k][1:0], 1'b1, 1'b1);
      writeCnt(VN[k][7:0]);
      writeCfg(1'b1, VSEL[k][1:0], 1'b1, 1'b1);
      waitFall(ok);
      check("R7 first pulse seen", ok, 1);
      width = 1; period = 0; inLow = 1; prev = 1'b0;
      for (int i = 0; i < 10000; i++) begin
        @(negedge clk);
        period++;
        if (prev && !intN) break;
        if (inLow && !intN) width++;
        else inLow = 0;
        prev = intN;
      end
      check($sformatf("R7 width vec%0d", k), width, VW[k]);
      check($sformatf("R3 period vec%0d", k), period, VP[k]);
    end

    // R8 interrupt disabled in pulse mode
    writeCfg(1'b0, 2'b00, 1'b0, 1'b1);
    writeFlag(1'b0);
    writeCnt(8'd1);
    writeCfg(1'b1, 2'b00, 1'b0, 1'b1);
    lowCnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!intN) lowCnt++;
    end
    check("R8 no low samples", lowCnt, 0);
    check("R8 flag still sets", flagRd, 1);

    // R10 disable during a pulse
    writeCfg(1'b0, 2'b01, 1'b1, 1'b1);
    writeCnt(8'd2);
    writeCfg(1'b1, 2'b01, 1'b1, 1'b1);
    waitFall(ok);
    repeat (10) @(negedge clk);
    check("R10 mid pulse low", intN, 0);
    writeCfg(1'b0, 2'b01, 1'b1, 1'b1);
    check("R10 pulse ended", intN, 1);
    v = cntRd;
    repeat (300) @(negedge clk);
    check("R10 frozen", cntRd, v);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule